// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider

This block turns one fast source clock into three banks of output clocks plus one feedback clock. Each bank and the feedback output has its own divider. Small select buses pick each ratio from a fixed table of even values. All logic runs on one system clock `clk`. Edges of the fast source and of the reference clock arrive as one-cycle enables, `src_ce` and `ref_ce`. Every divider advances on a single shared tick, so the rising edges of all banks stay aligned to the same source edge.

An optional divide-by-two stage sits in front of the dividers when the source is in use. A bypass mode feeds reference edges straight to the dividers, with no pre-stage. The active-low master reset `mr_oe_n` clears every divider and drops the output-enable strobe that a pad ring uses to float the pins. While disabled, the data outputs are held low. The two upper outputs of the third bank can be inverted.

Top module: `bank_clock_divider`

## Requirements
- R1: With `mr_oe_n` high, bank A (`qa`) divides by 4, 6, 8 or 12 for `sel_a` = 0, 1, 2, 3. All of its bits carry the same level.
- R2: Bank B (`qb`) divides by 4, 6, 8 or 10 for `sel_b` = 0, 1, 2, 3.
- R3: Bank C (`qc`) divides by 2, 4, 6 or 8 for `sel_c` = 0, 1, 2, 3.
- R4: The feedback output `qfb` divides by 4, 6, 8, 10, 8, 12, 16 or 20 for `sel_fb` = 0 to 7.
- R5: With `pll_on` = 1 and `vco_full` = 0, only every second `src_ce` pulse counted since release produces a divider tick (the 2nd, 4th, ...). With `vco_full` = 1, every `src_ce` pulse produces a tick.
- R6: With `pll_on` = 0, each `ref_ce` pulse produces one tick, and `src_ce` and `vco_full` have no effect on the outputs.
- R7: While `rst_n` or `mr_oe_n` is sampled low, all dividers and the pre-stage are cleared and all data outputs are 0. While `mr_oe_n` is low, `out_en` is 0, and otherwise it is 1.
- R8: With `inv_hi` = 1, the two upper bits of `qc` are the complement of the lower two. With `inv_hi` = 0, all four bits are equal.
- R9: Each divide-by-N output is high for the first N/2 ticks of its period and low for the remaining N/2 ticks.
- R10: The first tick after release sets every divider output high on the same clock edge.
- R11: A new ratio select is taken up only when the running period completes, or at the first tick after release. A period already started keeps its old length.
- R12: In a cycle with no tick, no divider output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ce | input | 1 | One-cycle enable per fast source edge |
| ref_ce | input | 1 | One-cycle enable per reference edge |
| pll_on | input | 1 | 1: source path, 0: reference bypass |
| vco_full | input | 1 | 1: source undivided, 0: source halved |
| mr_oe_n | input | 1 | Active-low master reset and output enable |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| inv_hi | input | 1 | Invert the two upper bank C bits |
| qa | output | BANK_W | Bank A clocks |
| qb | output | BANK_W | Bank B clocks |
| qc | output | BANK_W | Bank C clocks |
| qfb | output | 1 | Feedback clock |
| out_en | output | 1 | Pad drive enable, low while in master reset |

## Verification
The assertions check on every cycle that master reset clears the divider levels and lowers the output enable. They also check that levels hold still in cycles without a tick, that the halving pre-stage never passes two ticks in a row, and that the bank C polarity pair tracks `inv_hi`. Only the bench scenarios can show the actual ratios and the 50% shape of each period. The same holds for the common first rising edge after release, the deferred take-up of a changed select, and the bypass path ignoring the source.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants and ratio decode tables for the bank divider.
// Assumes every ratio is even and fits in RAT_W bits.
package clkdiv_pkg;
    localparam int RAT_W   = 5;
    localparam int NUM_DIV = 4;   // bank A, bank B, bank C, feedback

    // Bank A ratio decode
    function automatic logic [RAT_W-1:0] ratio_a(input logic [1:0] s);
        case (s)
            2'd0:    return RAT_W'(4);
            2'd1:    return RAT_W'(6);
            2'd2:    return RAT_W'(8);
            default: return RAT_W'(12);
        endcase
    endfunction

    // Bank B ratio decode
    function automatic logic [RAT_W-1:0] ratio_b(input logic [1:0] s);
        return RAT_W'(4 + 2 * int'(s));
    endfunction

    // Bank C ratio decode
    function automatic logic [RAT_W-1:0] ratio_c(input logic [1:0] s);
        return RAT_W'(2 + 2 * int'(s));
    endfunction

    // Feedback ratio decode: lower half steps by 2, upper half doubles the step
    function automatic logic [RAT_W-1:0] ratio_fb(input logic [2:0] s);
        if (!s[2]) return RAT_W'(4 + 2 * int'(s[1:0]));
        else       return RAT_W'(8 + 4 * int'(s[1:0]));
    endfunction
endpackage

// File: rtl/clk_tick_gen.sv
// Tick generator: picks the source or reference edge enable and applies the
// optional halving pre-stage on the source path.
// Assumes the enables are one clk cycle wide per edge.
module clk_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n,
    input  logic src_ce,
    input  logic ref_ce,
    input  logic pll_on,
    input  logic vco_full,
    output logic tick
);
    logic phase_q;

    // Pre-stage phase: flips on every source edge, cleared while held
    always_ff @(posedge clk) begin
        if (!rst_n || !hold_n)
            phase_q <= 1'b0;
        else if (src_ce)
            phase_q <= ~phase_q;
    end

    // Tick selection: halved or full source, or the reference in bypass
    always_comb begin
        if (pll_on)
            tick = src_ce & (vco_full | phase_q);
        else
            tick = ref_ce;
    end
endmodule

// File: rtl/ratio_divider.sv
// Even-ratio divider: the level is high for the first half of each period,
// starts high on the first tick after release, and takes up a new ratio
// only at a period boundary.
// Assumes ratio is even and at least 2.
module ratio_divider #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] ratio,
    output logic             lvl
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ncur_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;

    // Next position and period-end detect
    always_comb begin
        cnt_nxt = cnt_q + CNT_W'(1);
        wrap    = (cnt_q == ncur_q - CNT_W'(1));
    end

    // Period state: restart and load the ratio at a boundary, otherwise advance
    always_ff @(posedge clk) begin
        if (!rst_n || !hold_n) begin
            cnt_q  <= '0;
            ncur_q <= '0;
            run_q  <= 1'b0;
            lvl    <= 1'b0;
        end else if (tick) begin
            if (!run_q || wrap) begin
                cnt_q  <= '0;
                ncur_q <= ratio;
                run_q  <= 1'b1;
                lvl    <= 1'b1;
            end else begin
                cnt_q  <= cnt_nxt;
                lvl    <= (cnt_nxt < (ncur_q >> 1));
            end
        end
    end
endmodule

// File: rtl/bank_clock_divider.sv
// Top: three output banks and one feedback clock, each driven by its own
// divider from one shared tick, so their rising edges stay aligned.
// Assumes one clk domain, with source and reference edges given as enables.
module bank_clock_divider
    import clkdiv_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_ce,
    input  logic              ref_ce,
    input  logic              pll_on,
    input  logic              vco_full,
    input  logic              mr_oe_n,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic [1:0]        sel_c,
    input  logic [2:0]        sel_fb,
    input  logic              inv_hi,
    output logic [BANK_W-1:0] qa,
    output logic [BANK_W-1:0] qb,
    output logic [BANK_W-1:0] qc,
    output logic              qfb,
    output logic              out_en
);
    localparam int INV_FROM = BANK_W - 2;

    logic                     tick;
    logic [NUM_DIV-1:0]       lvl;
    logic [CNT_W-1:0]         rat [NUM_DIV];

    clk_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_n   (mr_oe_n),
        .src_ce   (src_ce),
        .ref_ce   (ref_ce),
        .pll_on   (pll_on),
        .vco_full (vco_full),
        .tick     (tick)
    );

    // Ratio decode for each divider from its select bus
    always_comb begin
        rat[0] = CNT_W'(ratio_a(sel_a));
        rat[1] = CNT_W'(ratio_b(sel_b));
        rat[2] = CNT_W'(ratio_c(sel_c));
        rat[3] = CNT_W'(ratio_fb(sel_fb));
    end

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        ratio_divider #(.CNT_W(CNT_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold_n (mr_oe_n),
            .tick   (tick),
            .ratio  (rat[d]),
            .lvl    (lvl[d])
        );
    end

    // Bank fan-out; the upper bank C pair takes the polarity option
    for (genvar i = 0; i < BANK_W; i++) begin : g_fan
        assign qa[i] = mr_oe_n & lvl[0];
        assign qb[i] = mr_oe_n & lvl[1];
        if (i >= INV_FROM) begin : g_inv
            assign qc[i] = mr_oe_n & (lvl[2] ^ inv_hi);
        end else begin : g_pass
            assign qc[i] = mr_oe_n & lvl[2];
        end
    end

    assign qfb    = mr_oe_n & lvl[3];
    assign out_en = mr_oe_n;
endmodule

// File: rtl/bank_clock_divider_chk.sv
// Checker: cycle-level properties of the bank divider, bound to the top.
// Assumes the top's internal tick and divider level vector are visible.
module bank_clock_divider_chk #(
    parameter int BANK_W  = 4,
    parameter int NUM_DIV = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mr_oe_n,
    input logic              tick,
    input logic [NUM_DIV-1:0] lvl,
    input logic [BANK_W-1:0] qa,
    input logic [BANK_W-1:0] qc,
    input logic              out_en,
    input logic              inv_hi,
    input logic              pll_on,
    input logic              vco_full
);
    // R7: disabled outputs are low and the pad enable is dropped
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_oe_n |-> (!out_en && qa == '0));

    // R7: master reset clears every divider level by the next edge
    p_hold_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_oe_n |=> (lvl == '0));

    // R12: without a tick no divider level moves
    p_no_tick_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && mr_oe_n) |=> $stable(lvl));

    // R5: the halving pre-stage never passes ticks on back-to-back cycles
    p_half_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pll_on && !vco_full) |=> !(tick && pll_on && !vco_full));

    // R8: the upper bank C bit is the lower one xor the polarity option
    p_inv_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mr_oe_n |-> (qc[BANK_W-1] == (qc[0] ^ inv_hi)));
endmodule

bind bank_clock_divider bank_clock_divider_chk #(
    .BANK_W  (BANK_W),
    .NUM_DIV (clkdiv_pkg::NUM_DIV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_oe_n  (mr_oe_n),
    .tick     (tick),
    .lvl      (lvl),
    .qa       (qa),
    .qc       (qc),
    .out_en   (out_en),
    .inv_hi   (inv_hi),
    .pll_on   (pll_on),
    .vco_full (vco_full)
);

// File: tb/bank_clock_divider_tb_top.sv
module bank_clock_divider_tb_top;
    localparam int BW = 4;
    localparam int NV = 8;
    // fields: sel_a[11:10] sel_b[9:8] sel_c[7:6] sel_fb[5:3] vco[2] pll[1] inv[0]
    localparam logic [11:0] VEC [NV] = '{
        12'b00_00_00_000_1_1_0,
        12'b01_01_01_001_1_1_1,
        12'b10_10_10_010_0_1_0,
        12'b11_11_11_011_1_1_1,
        12'b00_01_10_100_1_0_0,
        12'b01_10_11_101_0_0_1,
        12'b10_11_00_110_1_1_0,
        12'b11_00_01_111_0_1_1
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, src_ce, ref_ce, pll_on, vco_full, mr_oe_n, inv_hi;
    logic [1:0] sel_a, sel_b, sel_c;
    logic [2:0] sel_fb;
    logic [BW-1:0] qa, qb, qc;
    logic qfb, out_en;

    bank_clock_divider #(.BANK_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_ce(src_ce), .ref_ce(ref_ce),
        .pll_on(pll_on), .vco_full(vco_full), .mr_oe_n(mr_oe_n),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .inv_hi(inv_hi), .qa(qa), .qb(qb), .qc(qc), .qfb(qfb), .out_en(out_en)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench-side settings applied at the next drive point
    logic b_rst = 1'b0, b_mr = 1'b1, b_pll = 1'b1, b_vco = 1'b1, b_inv = 1'b0;
    logic [1:0] b_sa = '0, b_sb = '0, b_sc = '0;
    logic [2:0] b_fb = '0;

    // reference model state
    bit m_ph;
    bit m_run [4];
    int m_pos [4];
    int m_n   [4];

    function automatic int exp_ratio(input int k);
        case (k)
            0: case (b_sa) 0: return 4; 1: return 6; 2: return 8; default: return 12; endcase
            1: case (b_sb) 0: return 4; 1: return 6; 2: return 8; default: return 10; endcase
            2: case (b_sc) 0: return 2; 1: return 4; 2: return 6; default: return 8; endcase
            default: case (b_fb)
                0: return 4; 1: return 6; 2: return 8; 3: return 10;
                4: return 8; 5: return 12; 6: return 16; default: return 20;
            endcase
        endcase
    endfunction

    function automatic bit m_lvl(input int k);
        return m_run[k] && (m_pos[k] < m_n[k] / 2);
    endfunction

    task automatic cyc(input logic s, input logic r, input string tag);
        logic [13:0] exp_v, got_v;
        bit la, lb, lc, lf;
        @(negedge clk);
        la = m_lvl(0); lb = m_lvl(1); lc = m_lvl(2); lf = m_lvl(3);
        if (!mr_oe_n) exp_v = '0;
        else exp_v = {1'b1, lf, {2{lc ^ inv_hi}}, {2{lc}}, {BW{lb}}, {BW{la}}};
        got_v = {out_en, qfb, qc, qb, qa};
        n_chk++;
        if (got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s t=%0t got %b exp %b", tag, $time, got_v, exp_v);
        end
        rst_n = b_rst; mr_oe_n = b_mr; pll_on = b_pll; vco_full = b_vco; inv_hi = b_inv;
        sel_a = b_sa; sel_b = b_sb; sel_c = b_sc; sel_fb = b_fb;
        src_ce = s; ref_ce = r;
        if (!b_rst || !b_mr) begin
            m_ph = 0;
            for (int k = 0; k < 4; k++) begin m_run[k] = 0; m_pos[k] = 0; m_n[k] = 0; end
        end else begin
            bit t;
            t = b_pll ? (s && (b_vco || m_ph)) : r;
            if (s) m_ph = !m_ph;
            if (t) begin
                for (int k = 0; k < 4; k++) begin
                    if (!m_run[k] || m_pos[k] == m_n[k] - 1) begin
                        m_run[k] = 1; m_pos[k] = 0; m_n[k] = exp_ratio(k);
                    end else m_pos[k]++;
                end
            end
        end
    endtask

    initial begin
        rst_n = 0; mr_oe_n = 1; pll_on = 1; vco_full = 1; inv_hi = 0;
        src_ce = 0; ref_ce = 0; sel_a = 0; sel_b = 0; sel_c = 0; sel_fb = 0;
        for (int k = 0; k < 4; k++) begin m_run[k] = 0; m_pos[k] = 0; m_n[k] = 0; end
        m_ph = 0;

        // reset state: source edges under reset leave all outputs low (R7)
        for (int c = 0; c < 4; c++) cyc(1'b1, 1'b1, "R7 reset");
        b_rst = 1;
        cyc(1'b0, 1'b0, "R7 reset");

        // table walk: ratios, pre-stage, bypass, polarity, duty, alignment
        for (int v = 0; v < NV; v++) begin
            b_sa = VEC[v][11:10]; b_sb = VEC[v][9:8]; b_sc = VEC[v][7:6];
            b_fb = VEC[v][5:3]; b_vco = VEC[v][2]; b_pll = VEC[v][1]; b_inv = VEC[v][0];
            b_mr = 0;
            cyc(1'b1, 1'b0, "R7 hold");
            cyc(1'b1, 1'b1, "R7 hold");
            b_mr = 1;
            for (int c = 0; c < 70; c++)
                cyc(c % 5 != 4, c % 3 == 0, "R1 R2 R3 R4 R5 R6 R8 R9 R10");
        end

        // bypass with no reference edges: source pulses are ignored (R6)
        b_pll = 0; b_mr = 0; cyc(1'b0, 1'b0, "R7 hold");
        b_mr = 1;
        for (int c = 0; c < 20; c++) cyc(1'b1, 1'b0, "R6 src ignored");

        // no ticks mid-run: outputs frozen (R12)
        b_pll = 1; b_vco = 1;
        for (int c = 0; c < 7; c++) cyc(1'b1, 1'b0, "R12 run");
        for (int c = 0; c < 10; c++) cyc(1'b0, 1'b1, "R12 idle");

        // master reset mid-run, then common first edge (R7, R10)
        b_mr = 0;
        for (int c = 0; c < 3; c++) cyc(1'b1, 1'b1, "R7 mid-run");
        b_mr = 1;
        for (int c = 0; c < 12; c++) cyc(1'b1, 1'b0, "R10 release");

        // ratio change inside a period is deferred to its end (R11)
        b_sa = 0; b_sc = 0; b_fb = 0; b_mr = 0; cyc(1'b0, 1'b0, "R7 hold");
        b_mr = 1;
        for (int c = 0; c < 3; c++) cyc(1'b1, 1'b0, "R11 before");
        b_sa = 3; b_sc = 3; b_fb = 7;
        for (int c = 0; c < 60; c++) cyc(1'b1, 1'b0, "R11 after");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule